// File: doc/BRIEF.md
# One-hot NFA character matcher

This block scans a stream of 8-bit characters for one fixed regular expression. It is built as a non-deterministic automaton. Each automaton state has its own flip-flop. On every accepted character, all transitions are evaluated at once, so any number of partial matches can be in progress at the same moment. The pattern is chosen when the block is built. The default pattern is `(a|b)*a(a|b){N}` with N = `TAIL_LEN` (8 by default). A second option recognises `(a|b)*cd`.

The start state is set again on every valid character, so a match may begin anywhere in the stream. This also removes the leading loop state: every edge into it is an epsilon edge, so it becomes a constant wire and costs no flip-flop. A character moves an active bit forward only when the character equals one of the literals on that edge. A state with several incoming edges ORs them together. The flag `match_o` is a registered pulse. It is raised for one clock in the cycle after a valid character that completes the pattern.

Top module: `nfa_char_matcher`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all state flip-flops clear. After that edge `match_o` reads 0.
- R2: A cycle with `in_valid` low changes no automaton state. Such cycles do not count as characters, so a pattern may be interrupted by any number of idle cycles and still match.
- R3: With the default pattern, `match_o` is 1 in the cycle after a valid character c[0] exactly when c[TAIL_LEN] equals 0x61 ('a') and c[0]..c[TAIL_LEN-1] each equal 0x61 or 0x62 ('b'). Here c[k] is the k-th valid character before c[0].
- R4: Any other byte inside that window of TAIL_LEN+1 characters stops that candidate match.
- R5: Overlapping candidates are tracked together. A run of 'a' of length L ≥ TAIL_LEN+1 gives L−TAIL_LEN consecutive match pulses.
- R6: A match is found no matter which characters came before the window, since the start state is live on every valid character.
- R7: `match_o` is 0 in the cycle after any cycle with `in_valid` low, so each accepting character gives exactly one pulse.
- R8: With `PATTERN_SEL`=1, `match_o` is 1 in the cycle after a valid 0x64 ('d') whose previous valid character was 0x63 ('c').
- R9: Literal comparison is exact on all 8 bits. Upper-case 0x41 ('A') and 0x42 ('B') do not stand in for 'a' and 'b'.
- R10: A reset in the middle of a stream discards every partial match in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | High when `in_char` carries a character this cycle |
| in_char | input | 8 | Character byte |
| match_o | output | 1 | One-clock pulse after a character that completes the pattern |

## Verification
The bench aims at overlapping matches. A design that keeps only one active state, as an unconverted DFA-style tracker would, misses the back-to-back pulses in a long run of 'a'. Idle cycles are placed inside a window. A design that advances on invalid cycles would match early or not at all, and a design that holds `match_o` high would pulse twice. Near-miss bytes are also tested: 'c' inside the window, upper-case letters, and a 'c'/'d' pair split by another byte. These expose a missing kill path or a loose comparison. A reset in the middle of a window checks that stale partial matches cannot complete once the stream resumes.

// File: rtl/nfa_match_pkg.sv
// Package: shared constants and build-time edge tables for the NFA matcher.
// Assumes 8-bit characters and a small fixed literal alphabet a..d.
package nfa_match_pkg;

    localparam int CHAR_W  = 8;
    localparam int NUM_LIT = 4;

    // Literal slots, in the order decoded by nfa_lit_decode.
    localparam int LIT_A = 0;
    localparam int LIT_B = 1;
    localparam int LIT_C = 2;
    localparam int LIT_D = 3;

    // Pattern selections.
    localparam int PAT_AB_TAIL = 0;
    localparam int PAT_CD      = 1;

    // Byte code of literal slot idx ('a' + idx).
    function automatic logic [CHAR_W-1:0] lit_code(input int idx);
        return 8'h61 + CHAR_W'(idx);
    endfunction

    // Number of state flip-flops the selected pattern needs.
    function automatic int state_count(input int sel, input int tail);
        return (sel == PAT_CD) ? 2 : tail + 1;
    endfunction

    // Literal set on the single incoming conditioned edge of state k.
    function automatic logic [NUM_LIT-1:0] edge_mask(input int sel, input int k);
        logic [NUM_LIT-1:0] m;
        m = '0;
        if (sel == PAT_CD) begin
            if (k == 0) m[LIT_C] = 1'b1;
            else        m[LIT_D] = 1'b1;
        end else begin
            m[LIT_A] = 1'b1;
            if (k != 0) m[LIT_B] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nfa_lit_decode.sv
// Module: nfa_lit_decode
// Compares the incoming byte against every literal at once and returns one hit
// bit per literal slot. Purely combinational; at most one bit is set.
module nfa_lit_decode
    import nfa_match_pkg::*;
(
    input  logic [CHAR_W-1:0]  char_i,
    output logic [NUM_LIT-1:0] hit_o
);

    // One exact 8-bit comparator per literal slot.
    for (genvar i = 0; i < NUM_LIT; i++) begin : g_cmp
        assign hit_o[i] = (char_i == lit_code(i));
    end

endmodule

// File: rtl/nfa_state_cell.sv
// Module: nfa_state_cell
// One automaton state: a single flip-flop that becomes active when its source
// is active and the current character hits a literal in EDGE_MASK. Updates only
// when en_i is high; synchronous active-low reset clears it.
module nfa_state_cell
    import nfa_match_pkg::*;
#(
    parameter logic [NUM_LIT-1:0] EDGE_MASK = '0
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               src_i,
    input  logic [NUM_LIT-1:0] hit_i,
    output logic               q_o
);

    logic edge_take;

    // Conditioned incoming edge: source active and literal matched.
    assign edge_take = src_i & (|(hit_i & EDGE_MASK));

    // State flip-flop, advancing only on accepted characters.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= 1'b0;
        else if (en_i) q_o <= edge_take;
    end

    // Reset empties the state.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !q_o);

    // Idle cycles leave the state untouched.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(q_o));

    // No activation without an active predecessor.
    assert_needs_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !src_i) |=> !q_o);

endmodule

// File: rtl/nfa_char_matcher.sv
// Module: nfa_char_matcher (top)
// Streaming matcher for one fixed regular expression, kept in NFA form with
// one flip-flop per state. The leading (a|b)* loop is folded into a start
// state that is a constant 1, so matching starts at every offset. match_o is
// a one-clock pulse after each character that activates the accepting state.
module nfa_char_matcher
    import nfa_match_pkg::*;
#(
    parameter int PATTERN_SEL = PAT_AB_TAIL,
    parameter int TAIL_LEN    = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    output logic              match_o
);

    localparam int NSTATE = state_count(PATTERN_SEL, TAIL_LEN);

    logic [NUM_LIT-1:0] hit;
    logic [NSTATE-1:0]  state_q;
    logic [NSTATE-1:0]  src;
    logic               fresh_q;

    nfa_lit_decode u_dec (
        .char_i (in_char),
        .hit_o  (hit)
    );

    // Chain of state cells; state 0 is fed by the always-live start wire.
    for (genvar k = 0; k < NSTATE; k++) begin : g_state
        localparam logic [NUM_LIT-1:0] MASK = edge_mask(PATTERN_SEL, k);
        if (k == 0) begin : g_first
            assign src[k] = 1'b1;
        end else begin : g_next
            assign src[k] = state_q[k-1];
        end
        nfa_state_cell #(.EDGE_MASK(MASK)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (in_valid),
            .src_i (src[k]),
            .hit_i (hit),
            .q_o   (state_q[k])
        );
    end

    // Marks that the last cycle carried a character, limiting match to one pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fresh_q <= 1'b0;
        else        fresh_q <= in_valid;
    end

    assign match_o = state_q[NSTATE-1] & fresh_q;

    // A cycle without a character never yields a pulse in the next cycle.
    assert_idle_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !match_o);

    // The c-state and d-state of the second pattern cannot be active together.
    if (PATTERN_SEL == PAT_CD) begin : g_cd_chk
        assert_cd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(state_q));
    end

endmodule

// File: tb/nfa_char_matcher_tb.sv
`timescale 1ns/1ps
module nfa_char_matcher_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_char = 8'h00;
    logic       m_ab;
    logic       m_cd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] hist [0:8];
    int vcount = 0;

    always #2.5 clk = ~clk;

    nfa_char_matcher #(.PATTERN_SEL(0), .TAIL_LEN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char), .match_o(m_ab));

    nfa_char_matcher #(.PATTERN_SEL(1), .TAIL_LEN(8)) u_dut_cd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char), .match_o(m_cd));

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: match=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive one cycle (valid char or idle) and check both variants against the model.
    task automatic step(input logic v, input logic [7:0] ch, input string tag);
        logic exp_ab;
        logic exp_cd;
        in_valid = v;
        in_char  = ch;
        if (v) begin
            for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = ch;
            vcount++;
        end
        exp_ab = v && (vcount >= 9) && (hist[8] == 8'h61);
        for (int i = 0; i < 8; i++)
            if (!(hist[i] == 8'h61 || hist[i] == 8'h62)) exp_ab = 1'b0;
        exp_cd = v && (vcount >= 2) && (hist[0] == 8'h64) && (hist[1] == 8'h63);
        @(negedge clk);
        check({tag, " ab-pattern"}, m_ab, exp_ab);
        check({tag, " cd-pattern"}, m_cd, exp_cd);
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) step(1'b1, s[i], tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
    endtask

    // R1: reset clears everything.
    task automatic t_reset(input string tag);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        vcount = 0;
        for (int i = 0; i < 9; i++) hist[i] = 8'h00;
        check({tag, " ab"}, m_ab, 1'b0);
        check({tag, " cd"}, m_cd, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();        // R3
        send_str("ababababa", "R3 basic");
        idle(1, "R7 after basic");
    endtask

    task automatic t_idle_gap();     // R2
        send_str("aabab", "R2 pre-gap");
        idle(3, "R2 gap");
        send_str("abba", "R2 post-gap");
    endtask

    task automatic t_break();        // R4
        send_str("aabcabbbbbb", "R4 kill");
        send_str("bbbaaabbbbab", "R4 recover");
    endtask

    task automatic t_overlap();      // R5, R7
        send_str("aaaaaaaaaaaaa", "R5 overlap");
        idle(1, "R7 pulse end");
        step(1'b1, "a", "R7 resume");
    endtask

    task automatic t_offset();       // R6
        send_str("xyz09cdq", "R6 junk");
        send_str("baaaaaaab", "R6 offset");
    endtask

    task automatic t_case();         // R9
        send_str("zAbbbbbbbb", "R9 upper A");
        send_str("zaBabababa", "R9 upper B");
    endtask

    task automatic t_cd();           // R8
        send_str("abcdcd", "R8 pairs");
        step(1'b1, "c", "R8 split");
        idle(2, "R8 split gap");
        step(1'b1, "d", "R8 split");
        send_str("cxdccdd", "R8 near-miss");
    endtask

    task automatic t_mid_reset();    // R10
        send_str("zabbbbb", "R10 pre-reset");
        step(1'b1, "c", "R10 pre-reset");
        t_reset("R10 reset");
        send_str("bbbd", "R10 post-reset");
    endtask

    initial begin
        for (int i = 0; i < 9; i++) hist[i] = 8'h00;
        @(negedge clk);
        t_reset("R1 reset");
        t_basic();
        t_idle_gap();
        t_break();
        t_overlap();
        t_offset();
        t_case();
        t_cd();
        t_mid_reset();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): finished=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule